// File: doc/BRIEF.md
# Host Buffer Data Port

This block connects a host processor bus to a byte-wide local SRAM that holds network packets. The host talks to a small register file through a 4-bit register address. One address is the buffer data port. Each access to that port moves data between the host and the SRAM location named by an internal buffer pointer, and then advances the pointer.

The host bus runs 8 or 16 bits wide. The width comes up as 8-bit after reset and is chosen by a configuration bit. In 16-bit mode a word access to the data port becomes two byte cycles on the SRAM, one after the other. The host ready pulse is held back until both cycles are done. A byte-order bit decides which half of the host word goes to the lower SRAM address. That bit acts only on the data port and only in 16-bit mode; registers are never byte-swapped. A size bit selects a small or a large buffer, and the pointer wraps within the selected size.

Register map (byte addresses):
- 0x0: configuration A. Bit 5 is the narrow-bus bit; bit 1 selects the large buffer.
- 0x1: configuration B. Bit 0 is the byte-order bit.
- 0x2: pointer, low byte.
- 0x3: pointer, high byte.
- 0x4: data port.

A word access on the 16-bit bus addresses an even/odd pair of registers. The even register is carried on bits 7:0 and the odd one on bits 15:8.

Top module: `buf_data_port`

## Requirements
- R1: After reset, configuration A reads 0x20, configuration B reads 0x00, the pointer reads 0, and `bus16` is low.
- R2: Configuration A bit 5 set to 1 selects the 8-bit host bus; cleared to 0 it selects the 16-bit bus. `bus16` always shows the inverse of that bit.
- R3: Configuration A bit 1 selects the buffer size: 0 gives SMALL_BYTES, 1 gives LARGE_BYTES. The pointer, and every SRAM address it produces, wraps modulo the selected size, including the second byte of a word access and a pointer load.
- R4: A byte access to the data port (address 0x4) makes exactly one SRAM cycle at the pointer and advances the pointer by 1. A write stores `hwdata[7:0]`; a read returns the byte on `hrdata[7:0]` with bits 15:8 zero.
- R5: In 16-bit mode a word access to the data port makes exactly two SRAM cycles, at pointer and pointer+1, and advances the pointer by 2. `hready` is asserted only after the second byte is complete.
- R6: In a word access with byte-order bit 0, `hwdata[7:0]` / `hrdata[7:0]` maps to the lower SRAM address. With the bit set to 1, bits 15:8 map to the lower address.
- R7: In 8-bit mode the word select and the byte-order bit have no effect: every data-port access is a single unswapped byte cycle.
- R8: Word accesses to registers other than the data port are never swapped: the even register always appears on bits 7:0.
- R9: Writes to addresses 0x2 and 0x3 load the pointer's low and high bytes, and reads of those addresses return the current pointer.
- R10: Each completed access produces a `hready` pulse exactly one cycle long. A register access completes one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreq | input | 1 | Host access request, one cycle, accepted when idle |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | 4 | Register address |
| hword | input | 1 | Word access (used only on the 16-bit bus) |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, valid with hready |
| hready | output | 1 | One-cycle completion pulse |
| sram_en | output | 1 | SRAM cycle enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | $clog2(LARGE_BYTES) | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after an enabled read |
| bus16 | output | 1 | High when the 16-bit host bus is selected |

## Verification
A pointer that is off by one or has a wrong wrap mask shows up on `sram_addr` in the very next data-port access. It also shows up when the pointer registers are read back through the host port. A sequencer that swaps the wrong lane or skips a byte leaves the bench's SRAM model holding a wrong byte at a known address. Counting SRAM enables between a request and its `hready` pulse exposes a word access cut short, or a ready pulse issued before the second byte, within that same access.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FIRST = 2'd1,
    SQ_SECND = 2'd2,
    SQ_GRAB  = 2'd3
  } sq_state_e;

  localparam logic [3:0] RA_CFG_A  = 4'h0;
  localparam logic [3:0] RA_CFG_B  = 4'h1;
  localparam logic [3:0] RA_PTR_LO = 4'h2;
  localparam logic [3:0] RA_PTR_HI = 4'h3;
  localparam logic [3:0] RA_DATA   = 4'h4;

  localparam int NARROW_BIT = 5;
  localparam int BIG_BIT    = 1;
  localparam int SWAP_BIT   = 0;

  localparam logic [7:0] CFG_A_RESET = 8'h20;
endpackage

// File: rtl/bdp_cfg.sv
module bdp_cfg
  import bdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] val_a,
  input  logic [7:0] val_b,
  output logic [7:0] cfg_a,
  output logic [7:0] cfg_b,
  output logic       narrow,
  output logic       big,
  output logic       swap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a <= CFG_A_RESET;
      cfg_b <= 8'h00;
    end else begin
      if (wr_a) cfg_a <= val_a;
      if (wr_b) cfg_b <= val_b;
    end
  end

  assign narrow = cfg_a[NARROW_BIT];
  assign big    = cfg_a[BIG_BIT];
  assign swap   = cfg_b[SWAP_BIT];
endmodule

// File: rtl/bdp_ptr.sv
module bdp_ptr #(
  parameter int SMALL_BYTES = 8192,
  parameter int LARGE_BYTES = 32768,
  localparam int AW = $clog2(LARGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          big,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    lo_val,
  input  logic [7:0]    hi_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] mask
);
  localparam logic [AW-1:0] MASK_S = AW'(SMALL_BYTES - 1);
  localparam logic [AW-1:0] MASK_L = AW'(LARGE_BYTES - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] nxt;
  logic [AW-1:0] loaded;

  assign mask = big ? MASK_L : MASK_S;
  assign ptr  = ptr_q & mask;

  always_comb begin
    loaded = ptr_q;
    if (ld_lo) loaded[7:0] = lo_val;
    if (ld_hi) loaded = AW'({hi_val, loaded[7:0]});
    if (inc) nxt = (ptr + AW'(1)) & mask;
    else     nxt = loaded & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (inc || ld_lo || ld_hi) ptr_q <= nxt;
  end
endmodule

// File: rtl/bdp_seq.sv
module bdp_seq
  import bdp_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_wr,
  input  logic          is_word,
  input  logic          swap,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] mask,
  output logic          ptr_inc,
  output logic          busy,
  output logic          done,
  output logic [15:0]   rdata,
  output logic          sram_en,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  input  logic [7:0]    sram_rdata
);
  sq_state_e st;
  logic      wr_q;
  logic      word_q;
  logic      hi_first;
  logic [7:0] second_q;
  logic      issue0;
  logic      issue1;
  logic      hi_now;

  assign issue0  = (st == SQ_IDLE) && start;
  assign issue1  = (st == SQ_FIRST) && word_q;
  assign ptr_inc = issue0 || issue1;
  assign busy    = (st != SQ_IDLE);
  assign hi_now  = is_word && swap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      wr_q       <= 1'b0;
      word_q     <= 1'b0;
      hi_first   <= 1'b0;
      second_q   <= 8'h00;
      done       <= 1'b0;
      rdata      <= 16'h0000;
      sram_en    <= 1'b0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= 8'h00;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            wr_q       <= is_wr;
            word_q     <= is_word;
            hi_first   <= hi_now;
            second_q   <= hi_now ? wdata[7:0] : wdata[15:8];
            sram_en    <= 1'b1;
            sram_we    <= is_wr;
            sram_addr  <= ptr;
            sram_wdata <= hi_now ? wdata[15:8] : wdata[7:0];
            rdata      <= 16'h0000;
            st         <= SQ_FIRST;
          end
        end
        SQ_FIRST: begin
          if (word_q) begin
            sram_addr  <= ptr;
            sram_wdata <= second_q;
            st         <= SQ_SECND;
          end else begin
            sram_en <= 1'b0;
            sram_we <= 1'b0;
            if (wr_q) begin
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else begin
              st <= SQ_GRAB;
            end
          end
        end
        SQ_SECND: begin
          sram_en <= 1'b0;
          sram_we <= 1'b0;
          if (wr_q) begin
            done <= 1'b1;
            st   <= SQ_IDLE;
          end else begin
            if (hi_first) rdata[15:8] <= sram_rdata;
            else          rdata[7:0]  <= sram_rdata;
            st <= SQ_GRAB;
          end
        end
        SQ_GRAB: begin
          if (word_q && !hi_first) rdata[15:8] <= sram_rdata;
          else                     rdata[7:0]  <= sram_rdata;
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_SECOND_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_SECND) |-> (sram_addr == ((AW'($past(sram_addr)) + AW'(1)) & mask))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> sram_en); // R4
endmodule

// File: rtl/buf_data_port.sv
module buf_data_port
  import bdp_pkg::*;
#(
  parameter int SMALL_BYTES = 8192,
  parameter int LARGE_BYTES = 32768,
  localparam int AW = $clog2(LARGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hreq,
  input  logic          hwr,
  input  logic [3:0]    haddr,
  input  logic          hword,
  input  logic [15:0]   hwdata,
  output logic [15:0]   hrdata,
  output logic          hready,
  output logic          sram_en,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  input  logic [7:0]    sram_rdata,
  output logic          bus16
);
  localparam int NREG = 4;

  logic [7:0]    cfg_a, cfg_b;
  logic          narrow, big, swap;
  logic [AW-1:0] ptr, mask;
  logic          ptr_inc, busy, seq_done;
  logic [15:0]   seq_rd;
  logic          word_eff, accept, is_data;
  logic [3:0]    base;
  logic [NREG-1:0] reg_we;
  logic [7:0]    reg_wv [NREG];
  logic [7:0]    reg_rv [NREG];
  logic [7:0]    rd_lo, rd_hi;
  logic          reg_ack_q;
  logic [15:0]   reg_rd_q;

  assign word_eff = hword && !narrow;
  assign base     = word_eff ? {haddr[3:1], 1'b0} : haddr;
  assign is_data  = (base == RA_DATA);
  assign accept   = hreq && !busy;

  for (genvar r = 0; r < NREG; r++) begin : g_regsel
    localparam logic [3:0] RADDR = 4'(r);
    assign reg_we[r] = accept && hwr && !is_data &&
                       (word_eff ? (base[3:1] == RADDR[3:1]) : (haddr == RADDR));
    assign reg_wv[r] = (word_eff && RADDR[0]) ? hwdata[15:8] : hwdata[7:0];
  end

  assign reg_rv[0] = cfg_a;
  assign reg_rv[1] = cfg_b;
  assign reg_rv[2] = ptr[7:0];
  assign reg_rv[3] = 8'(ptr[AW-1:8]);

  always_comb begin
    rd_lo = (base < 4'(NREG)) ? reg_rv[base[1:0]] : 8'h00;
    rd_hi = 8'h00;
    if (word_eff && (base < 4'(NREG))) rd_hi = reg_rv[{base[1], 1'b1}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack_q <= 1'b0;
      reg_rd_q  <= 16'h0000;
    end else begin
      reg_ack_q <= accept && !is_data;
      if (accept && !is_data) reg_rd_q <= hwr ? 16'h0000 : {rd_hi, rd_lo};
    end
  end

  bdp_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_a   (reg_we[0]),
    .wr_b   (reg_we[1]),
    .val_a  (reg_wv[0]),
    .val_b  (reg_wv[1]),
    .cfg_a  (cfg_a),
    .cfg_b  (cfg_b),
    .narrow (narrow),
    .big    (big),
    .swap   (swap)
  );

  bdp_ptr #(
    .SMALL_BYTES (SMALL_BYTES),
    .LARGE_BYTES (LARGE_BYTES)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .big    (big),
    .ld_lo  (reg_we[2]),
    .ld_hi  (reg_we[3]),
    .lo_val (reg_wv[2]),
    .hi_val (reg_wv[3]),
    .inc    (ptr_inc),
    .ptr    (ptr),
    .mask   (mask)
  );

  bdp_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept && is_data),
    .is_wr      (hwr),
    .is_word    (word_eff),
    .swap       (swap),
    .wdata      (hwdata),
    .ptr        (ptr),
    .mask       (mask),
    .ptr_inc    (ptr_inc),
    .busy       (busy),
    .done       (seq_done),
    .rdata      (seq_rd),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_rdata (sram_rdata)
  );

  assign hready = reg_ack_q || seq_done;
  assign hrdata = reg_ack_q ? reg_rd_q : seq_rd;
  assign bus16  = !narrow;

  AST_SMALL_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sram_en && !big) |-> (int'(sram_addr) < SMALL_BYTES)); // R3
  AST_NARROW_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (sram_en && narrow) |=> !sram_en); // R7
  AST_REG_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_data) |=> hready); // R10
endmodule

// File: tb/buf_data_port_bench.sv
module buf_data_port_bench;
  localparam int SB = 256;
  localparam int LB = 1024;
  localparam int AW = $clog2(LB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hreq = 1'b0, hwr = 1'b0, hword = 1'b0;
  logic [3:0] haddr = 4'h0;
  logic [15:0] hwdata = 16'h0;
  logic [15:0] hrdata;
  logic hready, sram_en, sram_we, bus16;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_wdata;
  logic [7:0] sram_rdata = 8'h00;
  logic [7:0] mem [LB];

  int tests = 0, fails = 0, en_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  buf_data_port #(.SMALL_BYTES(SB), .LARGE_BYTES(LB)) u_buf_data_port (
    .clk(clk), .rst(rst), .hreq(hreq), .hwr(hwr), .haddr(haddr), .hword(hword),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .sram_en(sram_en),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .bus16(bus16)
  );

  always @(posedge clk) begin
    if (sram_en) begin
      en_cnt = en_cnt + 1;
      if (sram_we) mem[sram_addr] <= sram_wdata;
      else         sram_rdata <= mem[sram_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic wd,
                     input logic [15:0] d, output logic [15:0] q);
    int n;
    en_cnt = 0;
    @(negedge clk);
    hreq = 1'b1; hwr = wr; haddr = a; hword = wd; hwdata = d;
    @(negedge clk);
    hreq = 1'b0;
    n = 0;
    while (!hready && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (n >= 50) chk(1'b0, "R10 ready timeout", 16'(n), 16'd0);
    q = hrdata;
  endtask

  task automatic wr16(input logic [3:0] a, input logic wd, input logic [15:0] d);
    logic [15:0] q;
    acc(1'b1, a, wd, d, q);
  endtask

  task automatic t_reset;
    logic [15:0] q;
    chk(bus16 == 1'b0, "R1 bus16 at reset", 16'(bus16), 16'd0);
    acc(1'b0, 4'h0, 1'b0, 16'h0, q); chk(q == 16'h0020, "R1 cfg A", q, 16'h0020);
    acc(1'b0, 4'h1, 1'b0, 16'h0, q); chk(q == 16'h0000, "R1 cfg B", q, 16'h0000);
    acc(1'b0, 4'h2, 1'b0, 16'h0, q); chk(q == 16'h0000, "R1 pointer", q, 16'h0000);
  endtask

  task automatic t_narrow;
    logic [15:0] q;
    wr16(4'h2, 1'b0, 16'h0010);
    wr16(4'h3, 1'b0, 16'h0000);
    acc(1'b0, 4'h2, 1'b0, 16'h0, q); chk(q == 16'h0010, "R9 pointer load", q, 16'h0010);
    wr16(4'h4, 1'b1, 16'hBEA1);
    chk(en_cnt == 1, "R7 word ignored on narrow bus", 16'(en_cnt), 16'd1);
    chk(mem[16] == 8'hA1, "R4 byte write", 16'(mem[16]), 16'h00A1);
    acc(1'b0, 4'h2, 1'b0, 16'h0, q); chk(q == 16'h0011, "R4 pointer +1", q, 16'h0011);
    wr16(4'h1, 1'b0, 16'h0001);
    wr16(4'h4, 1'b1, 16'h4477);
    chk(mem[17] == 8'h77, "R7 swap ignored on narrow bus", 16'(mem[17]), 16'h0077);
    wr16(4'h2, 1'b0, 16'h0010);
    acc(1'b0, 4'h4, 1'b1, 16'h0, q);
    chk(q == 16'h00A1, "R4 byte read upper zero", q, 16'h00A1);
    chk(en_cnt == 1, "R7 single read cycle", 16'(en_cnt), 16'd1);
    @(negedge clk);
    chk(hready == 1'b0, "R10 ready one cycle", 16'(hready), 16'd0);
    wr16(4'h1, 1'b0, 16'h0000);
  endtask

  task automatic t_wide;
    logic [15:0] q;
    wr16(4'h0, 1'b0, 16'h0000);
    chk(bus16 == 1'b1, "R2 bus16 inverse of narrow", 16'(bus16), 16'd1);
    wr16(4'h2, 1'b1, 16'h0020);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0020, "R9 word pointer read", q, 16'h0020);
    wr16(4'h4, 1'b1, 16'h1234);
    chk(en_cnt == 2, "R5 two cycles before ready", 16'(en_cnt), 16'd2);
    chk({mem[33], mem[32]} == 16'h1234, "R6 low byte first", {mem[33], mem[32]}, 16'h1234);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0022, "R5 pointer +2", q, 16'h0022);
    wr16(4'h0, 1'b1, 16'h0100);
    acc(1'b0, 4'h0, 1'b1, 16'h0, q); chk(q == 16'h0100, "R8 config pair unswapped", q, 16'h0100);
    wr16(4'h2, 1'b1, 16'h0030);
    wr16(4'h4, 1'b1, 16'h1234);
    chk({mem[49], mem[48]} == 16'h3412, "R6 high byte first", {mem[49], mem[48]}, 16'h3412);
    wr16(4'h2, 1'b1, 16'h0020);
    acc(1'b0, 4'h4, 1'b1, 16'h0, q); chk(q == 16'h3412, "R6 swapped read", q, 16'h3412);
    chk(en_cnt == 2, "R5 two read cycles", 16'(en_cnt), 16'd2);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0022, "R8 pointer pair unswapped", q, 16'h0022);
    wr16(4'h4, 1'b0, 16'h005A);
    chk(en_cnt == 1 && mem[34] == 8'h5A, "R4 byte access on wide bus", 16'(mem[34]), 16'h005A);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0023, "R4 pointer +1 wide", q, 16'h0023);
  endtask

  task automatic t_wrap;
    logic [15:0] q;
    wr16(4'h0, 1'b1, 16'h0000);
    wr16(4'h2, 1'b1, 16'h0300);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0000, "R3 load masked small", q, 16'h0000);
    wr16(4'h2, 1'b1, 16'h00FF);
    wr16(4'h4, 1'b1, 16'hABCD);
    chk(mem[255] == 8'hCD && mem[0] == 8'hAB, "R3 small wrap", {mem[0], mem[255]}, 16'hABCD);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0001, "R3 pointer after small wrap", q, 16'h0001);
    wr16(4'h0, 1'b1, 16'h0002);
    wr16(4'h2, 1'b1, 16'h00FF);
    wr16(4'h4, 1'b1, 16'h1122);
    chk(mem[255] == 8'h22 && mem[256] == 8'h11, "R3 large no wrap", {mem[256], mem[255]}, 16'h1122);
    wr16(4'h2, 1'b1, 16'h03FF);
    wr16(4'h4, 1'b1, 16'h6655);
    chk(mem[1023] == 8'h55 && mem[0] == 8'h66, "R3 large wrap", {mem[0], mem[1023]}, 16'h6655);
    acc(1'b0, 4'h2, 1'b1, 16'h0, q); chk(q == 16'h0001, "R3 pointer after large wrap", q, 16'h0001);
  endtask

  initial begin
    for (int i = 0; i < LB; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_narrow;
    t_wide;
    t_wrap;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule